// File: doc/BRIEF.md
# Unaligned Word Load/Store Merger

This block carries out the four partial-word memory instructions that move a word at an address which need not be word aligned: load-left, load-right, store-left and store-right. A command gives a 6-bit opcode, a base address, a signed displacement, an endianness select and one register value. For a load, that value is the current destination register. For a store, it is the store data. The block forms the effective address and clears its low bits to get the word address. It then reads that word over a simple valid/ready request port with a separate response strobe.

For a load, the word that comes back is merged byte lane by byte lane with the old register contents. The result is returned on a one-cycle completion strobe. For a store, the read word is merged with the selected register bytes, and the full word is then written back at the same word address with every byte enable set. No offset ever raises an alignment fault. A left/right pair therefore assembles or scatters a misaligned word in two commands.

The byte offset taken from the low address bits chooses which lanes are replaced and which are kept. Little-endian operation uses the same lane rules with the offset mirrored, that is replaced by three minus the offset.

Top module: `uwm_unaligned_merge`

## Requirements
- R1: Opcode 0x22 is load-left, 0x26 load-right, 0x2A store-left and 0x2E store-right. A command with any other opcode starts no memory request, produces no completion and leaves `busy` low.
- R2: The request address is base plus the sign-extended displacement with its two low bits cleared, for every offset 0 to 3. No alignment fault exists.
- R3: Big-endian load-left at offset k puts memory byte addresses k..3 into the register from the most significant lane downward and keeps the low k register bytes. Offset 0 copies the whole memory word.
- R4: Big-endian load-right at offset k puts memory byte addresses k down to 0 into the register from the least significant lane upward and keeps the upper 3-k register bytes. Offset 3 copies the whole word.
- R5: Big-endian store-left at offset k writes the register's most significant bytes into memory byte addresses k..3 and preserves the other memory bytes.
- R6: Big-endian store-right at offset k writes the register's least significant bytes into memory byte addresses k down to 0 and preserves the other memory bytes.
- R7: With `cmd_big_endian` low, each of the four merges uses offset 3-k in place of k. So load-left at offset 3 and load-right at offset 0 copy the whole word, and a load-right at A followed by a load-left at A+3 rebuilds a little-endian misaligned word.
- R8: A store issues exactly one read and no write until that read's response has arrived. It then issues exactly one write of the merged word to the same word address with `mem_req_be` all ones. `done_valid` follows one cycle after that write is accepted.
- R9: A load issues exactly one read and no write. `done_valid` rises in the cycle after the read response with the merged register on `done_data`, and it lasts one cycle.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid with the same address and direction in the next cycle.
- R11: A command presented while `busy` is high is ignored. The command in progress completes unchanged and no extra memory access or completion occurs.
- R12: During and right after synchronous reset, `busy`, `mem_req_valid` and `done_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken when `busy` is low |
| cmd_opcode | input | 6 | Instruction opcode |
| cmd_base | input | ADDR_W | Base address |
| cmd_disp | input | DISP_W | Signed displacement |
| cmd_big_endian | input | 1 | 1 selects big-endian lane rules |
| cmd_reg | input | DATA_W | Old destination register (loads) or store data (stores) |
| busy | output | 1 | A command is in progress |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 for write, 0 for read |
| mem_req_addr | output | ADDR_W | Word-aligned request address |
| mem_req_wdata | output | DATA_W | Merged word for a write |
| mem_req_be | output | DATA_W/8 | Byte enables |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | DATA_W | Read data |
| done_valid | output | 1 | One-cycle completion strobe |
| done_data | output | DATA_W | Merged register (loads) or written word (stores) |

## Verification
A command sampled at a clock edge shows up as a read request in the next cycle. The read response can arrive one to three cycles after acceptance, and the bench's memory model records the cycle it drives it.

For a load, the bench expects `done_valid` exactly one cycle after that response. For a store, it expects the write request after the response and `done_valid` exactly one cycle after the write is accepted. All outputs are sampled on the falling edge, and the bench compares those recorded cycle numbers rather than waiting loosely.

Merge results are compared against a byte-address walk computed in the bench. Write-back contents are compared through the memory model, and the request hold is checked on every stalled cycle while the ready signal is randomly withheld.

// File: rtl/uwm_pkg.sv
package uwm_pkg;

    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_LD_LEFT  = 6'h22;
    localparam logic [OPC_W-1:0] OPC_LD_RIGHT = 6'h26;
    localparam logic [OPC_W-1:0] OPC_ST_LEFT  = 6'h2A;
    localparam logic [OPC_W-1:0] OPC_ST_RIGHT = 6'h2E;

    typedef enum logic [1:0] {
        K_LD_LEFT  = 2'd0,
        K_LD_RIGHT = 2'd1,
        K_ST_LEFT  = 2'd2,
        K_ST_RIGHT = 2'd3
    } uwm_kind_e;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_RD   = 3'd1,
        S_WAIT = 3'd2,
        S_WR   = 3'd3,
        S_DONE = 3'd4
    } uwm_state_e;

    typedef struct packed {
        logic      legal;
        uwm_kind_e kind;
    } uwm_op_t;

    function automatic uwm_op_t classify(input logic [OPC_W-1:0] opc);
        uwm_op_t r;
        r.legal = 1'b1;
        case (opc)
            OPC_LD_LEFT:  r.kind = K_LD_LEFT;
            OPC_LD_RIGHT: r.kind = K_LD_RIGHT;
            OPC_ST_LEFT:  r.kind = K_ST_LEFT;
            OPC_ST_RIGHT: r.kind = K_ST_RIGHT;
            default: begin
                r.legal = 1'b0;
                r.kind  = K_LD_LEFT;
            end
        endcase
        return r;
    endfunction

    function automatic logic kind_is_store(input uwm_kind_e k);
        return (k == K_ST_LEFT) || (k == K_ST_RIGHT);
    endfunction

    // Whether result lane 'lane' (0 = least significant) is taken from the
    // fill word; 'ofs' is the big-endian-equivalent byte offset.
    function automatic logic lane_take(input uwm_kind_e k, input int lane,
                                       input int ofs, input int top);
        case (k)
            K_LD_LEFT:  return lane >= ofs;
            K_LD_RIGHT: return lane <= ofs;
            K_ST_LEFT:  return lane <= top - ofs;
            default:    return lane >= top - ofs;
        endcase
    endfunction

    // Fill-word lane that feeds result lane 'lane' when lane_take is true.
    function automatic int lane_src(input uwm_kind_e k, input int lane,
                                    input int ofs, input int top);
        case (k)
            K_LD_LEFT:  return lane - ofs;
            K_LD_RIGHT: return lane + top - ofs;
            K_ST_LEFT:  return lane + ofs;
            default:    return lane - (top - ofs);
        endcase
    endfunction

endpackage

// File: rtl/uwm_cmd_decode.sv
module uwm_cmd_decode
    import uwm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16,
    parameter int LANES  = 4,
    localparam int OFS_W = $clog2(LANES)
) (
    input  logic [OPC_W-1:0]  opcode,
    input  logic [ADDR_W-1:0] base,
    input  logic [DISP_W-1:0] disp,
    input  logic              big_endian,
    output uwm_op_t           op,
    output logic [ADDR_W-1:0] word_addr,
    output logic [OFS_W-1:0]  eff_ofs
);

    localparam logic [OFS_W-1:0] TOP_OFS = OFS_W'(LANES - 1);

    logic [ADDR_W-1:0] ea;
    logic [OFS_W-1:0]  raw_ofs;

    assign op        = classify(opcode);
    assign ea        = base + {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
    assign raw_ofs   = ea[OFS_W-1:0];
    assign word_addr = {ea[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
    // Little-endian lanes mirror the big-endian rules.
    assign eff_ofs   = big_endian ? raw_ofs : (TOP_OFS - raw_ofs);

endmodule

// File: rtl/uwm_lane_merge.sv
module uwm_lane_merge
    import uwm_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFS_W = $clog2(LANES)
) (
    input  uwm_kind_e          kind,
    input  logic [OFS_W-1:0]   ofs,
    input  logic [DATA_W-1:0]  fill,
    input  logic [DATA_W-1:0]  keep,
    output logic [DATA_W-1:0]  merged
);

    logic [LANES-1:0][7:0] fill_l;
    logic [LANES-1:0][7:0] keep_l;
    logic [LANES-1:0][7:0] out_l;

    assign fill_l = fill;
    assign keep_l = keep;
    assign merged = out_l;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        int               src;
        logic             take;
        logic [OFS_W-1:0] idx;
        always_comb begin
            take = lane_take(kind, g, int'(ofs), LANES - 1);
            src  = lane_src(kind, g, int'(ofs), LANES - 1);
            idx  = src[OFS_W-1:0];
            out_l[g] = take ? fill_l[idx] : keep_l[g];
        end
    end

endmodule

// File: rtl/uwm_ctrl.sv
module uwm_ctrl
    import uwm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFS_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  uwm_kind_e         acc_kind,
    input  logic [OFS_W-1:0]  acc_ofs,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_reg,
    output logic              busy,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    output logic [LANES-1:0]  mem_req_be,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata,
    output uwm_kind_e         mg_kind,
    output logic [OFS_W-1:0]  mg_ofs,
    output logic [DATA_W-1:0] mg_fill,
    output logic [DATA_W-1:0] mg_keep,
    input  logic [DATA_W-1:0] mg_word,
    output logic              done_valid,
    output logic [DATA_W-1:0] done_data
);

    localparam logic [OFS_W-1:0] TOP_OFS = OFS_W'(LANES - 1);

    uwm_state_e        state;
    uwm_kind_e         kind_q;
    logic [OFS_W-1:0]  ofs_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] reg_q;
    logic [DATA_W-1:0] word_q;
    logic              store_q;

    assign store_q = kind_is_store(kind_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            kind_q <= K_LD_LEFT;
            ofs_q  <= '0;
            addr_q <= '0;
            reg_q  <= '0;
            word_q <= '0;
        end else begin
            case (state)
                S_IDLE: if (acc_valid) begin
                    state  <= S_RD;
                    kind_q <= acc_kind;
                    ofs_q  <= acc_ofs;
                    addr_q <= acc_addr;
                    reg_q  <= acc_reg;
                end
                S_RD:   if (mem_req_ready) state <= S_WAIT;
                S_WAIT: if (mem_rsp_valid) begin
                    word_q <= mg_word;
                    state  <= store_q ? S_WR : S_DONE;
                end
                S_WR:   if (mem_req_ready) state <= S_DONE;
                S_DONE: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Loads fill from memory over the old register; stores fill from the
    // register over the old memory word.
    assign mg_kind = kind_q;
    assign mg_ofs  = ofs_q;
    assign mg_fill = store_q ? reg_q : mem_rsp_rdata;
    assign mg_keep = store_q ? mem_rsp_rdata : reg_q;

    assign busy          = (state != S_IDLE);
    assign mem_req_valid = (state == S_RD) || (state == S_WR);
    assign mem_req_write = (state == S_WR);
    assign mem_req_addr  = addr_q;
    assign mem_req_wdata = word_q;
    assign mem_req_be    = '1;
    assign done_valid    = (state == S_DONE);
    assign done_data     = word_q;

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

    // R8
    wr_after_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req_valid && mem_req_write) |-> $past(mem_rsp_valid));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !done_valid && !mem_req_valid);

    // R12
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !busy && !mem_req_valid && !done_valid);

    // R3
    full_left_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_WAIT) && mem_rsp_valid && (kind_q == K_LD_LEFT) && (ofs_q == '0)
            |-> mg_word == mem_rsp_rdata);

    // R4
    full_right_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_WAIT) && mem_rsp_valid && (kind_q == K_LD_RIGHT) && (ofs_q == TOP_OFS)
            |-> mg_word == mem_rsp_rdata);

endmodule

// File: rtl/uwm_unaligned_merge.sv
module uwm_unaligned_merge
    import uwm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DISP_W = 16,
    localparam int LANES = DATA_W / 8,
    localparam int OFS_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [5:0]        cmd_opcode,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [DISP_W-1:0] cmd_disp,
    input  logic              cmd_big_endian,
    input  logic [DATA_W-1:0] cmd_reg,
    output logic              busy,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    output logic [LANES-1:0]  mem_req_be,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata,
    output logic              done_valid,
    output logic [DATA_W-1:0] done_data
);

    uwm_op_t           dec_op;
    logic [ADDR_W-1:0] dec_addr;
    logic [OFS_W-1:0]  dec_ofs;
    uwm_kind_e         mg_kind;
    logic [OFS_W-1:0]  mg_ofs;
    logic [DATA_W-1:0] mg_fill;
    logic [DATA_W-1:0] mg_keep;
    logic [DATA_W-1:0] mg_word;

    uwm_cmd_decode #(
        .ADDR_W(ADDR_W),
        .DISP_W(DISP_W),
        .LANES (LANES)
    ) i_decode (
        .opcode    (cmd_opcode),
        .base      (cmd_base),
        .disp      (cmd_disp),
        .big_endian(cmd_big_endian),
        .op        (dec_op),
        .word_addr (dec_addr),
        .eff_ofs   (dec_ofs)
    );

    uwm_lane_merge #(
        .DATA_W(DATA_W)
    ) i_merge (
        .kind  (mg_kind),
        .ofs   (mg_ofs),
        .fill  (mg_fill),
        .keep  (mg_keep),
        .merged(mg_word)
    );

    uwm_ctrl #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) i_ctrl (
        .clk          (clk),
        .rst          (rst),
        .acc_valid    (cmd_valid && dec_op.legal),
        .acc_kind     (dec_op.kind),
        .acc_ofs      (dec_ofs),
        .acc_addr     (dec_addr),
        .acc_reg      (cmd_reg),
        .busy         (busy),
        .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write),
        .mem_req_addr (mem_req_addr),
        .mem_req_wdata(mem_req_wdata),
        .mem_req_be   (mem_req_be),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata),
        .mg_kind      (mg_kind),
        .mg_ofs       (mg_ofs),
        .mg_fill      (mg_fill),
        .mg_keep      (mg_keep),
        .mg_word      (mg_word),
        .done_valid   (done_valid),
        .done_data    (done_data)
    );

    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !done_valid |=> busy);

endmodule

// File: tb/test_uwm_unaligned_merge.sv
`timescale 1ns/1ps
module test_uwm_unaligned_merge;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [5:0]  cmd_opcode = '0;
    logic [31:0] cmd_base = '0;
    logic [15:0] cmd_disp = '0;
    logic        cmd_big_endian = 1'b1;
    logic [31:0] cmd_reg = '0;
    logic        busy;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic        mem_req_write;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic [3:0]  mem_req_be;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_rdata;
    logic        done_valid;
    logic [31:0] done_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int reads  = 0;
    int writes = 0;
    int rsp_cyc = 0;
    int wr_cyc  = 0;
    logic [31:0] last_rd_addr = '0;
    logic [31:0] last_wr_addr = '0;
    logic [3:0]  last_be = '0;
    logic [31:0] mem_m [16];

    uwm_unaligned_merge i_uwm_unaligned_merge (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
        .cmd_base(cmd_base), .cmd_disp(cmd_disp), .cmd_big_endian(cmd_big_endian),
        .cmd_reg(cmd_reg), .busy(busy), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_req_be(mem_req_be), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .done_valid(done_valid), .done_data(done_data)
    );

    always #2.5 clk = ~clk;

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference: walk byte addresses from the offset, filling register
    // significance from the top (left forms) or bottom (right forms).
    function automatic logic [31:0] ref_merge(input logic [5:0] opc, input logic be,
                                              input logic [1:0] ofs,
                                              input logic [31:0] regv,
                                              input logic [31:0] memw);
        logic [31:0] r = regv;
        logic [31:0] m = memw;
        bit left  = (opc == 6'h22) || (opc == 6'h2A);
        bit store = opc[3];
        int a = int'(ofs);
        int s = left ? 3 : 0;
        int dir = (left == be) ? 1 : -1;
        while (a >= 0 && a <= 3 && s >= 0 && s <= 3) begin
            int ml = be ? 3 - a : a;
            if (store) m[ml*8 +: 8] = r[s*8 +: 8];
            else       r[s*8 +: 8] = m[ml*8 +: 8];
            a += dir;
            s += left ? -1 : 1;
        end
        return store ? m : r;
    endfunction

    function automatic logic [7:0] mem_byte(input logic [31:0] ba, input logic be);
        logic [31:0] w = mem_m[ba[5:2]];
        int o = int'(ba[1:0]);
        return be ? w[(3-o)*8 +: 8] : w[o*8 +: 8];
    endfunction

    function automatic string tag_of(input logic [5:0] opc, input logic be);
        string t;
        case (opc)
            6'h22:   t = "R3";
            6'h26:   t = "R4";
            6'h2A:   t = "R5";
            default: t = "R6";
        endcase
        return be ? t : {t, "/R7"};
    endfunction

    // Memory model: random ready, read data one to three cycles later.
    initial begin : responder
        int cd = 0;
        logic [3:0] ra = '0;
        bit hold_pend = 0;
        logic [31:0] h_addr = '0;
        logic h_wr = 0;
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_rdata = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (cd > 0) begin
                cd--;
                if (cd == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_rdata = mem_m[ra];
                    rsp_cyc = cyc;
                end
            end
            if (hold_pend) begin
                // R10
                check(mem_req_valid && mem_req_addr == h_addr && mem_req_write == h_wr,
                      "R10 request hold", mem_req_addr, h_addr);
            end
            hold_pend = 0;
            mem_req_ready = ($urandom % 4) != 0;
            if (mem_req_valid && !rst) begin
                if (mem_req_ready) begin
                    if (mem_req_write) begin
                        writes++;
                        mem_m[mem_req_addr[5:2]] = mem_req_wdata;
                        last_wr_addr = mem_req_addr;
                        last_be = mem_req_be;
                        wr_cyc = cyc;
                    end else begin
                        reads++;
                        ra = mem_req_addr[5:2];
                        last_rd_addr = mem_req_addr;
                        cd = 1 + int'($urandom % 3);
                    end
                end else begin
                    hold_pend = 1;
                    h_addr = mem_req_addr;
                    h_wr = mem_req_write;
                end
            end
        end
    end

    task automatic do_op(input logic [5:0] opc, input logic [31:0] base,
                         input logic [15:0] disp, input logic be,
                         input logic [31:0] rv, input bit intrude,
                         output logic [31:0] res);
        int r0 = reads;
        int w0 = writes;
        int n = 0;
        bit store = opc[3];
        logic [31:0] ea = base + {{16{disp[15]}}, disp};
        logic [31:0] wa = {ea[31:2], 2'b00};
        logic [31:0] old = mem_m[ea[5:2]];
        logic [31:0] exp = ref_merge(opc, be, ea[1:0], rv, old);
        string t = tag_of(opc, be);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_opcode = opc; cmd_base = base; cmd_disp = disp;
        cmd_big_endian = be; cmd_reg = rv;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (intrude) begin
            @(negedge clk);
            cmd_valid = 1'b1; cmd_opcode = 6'h2E; cmd_reg = ~rv; cmd_big_endian = ~be;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        while (!done_valid && n < 60) begin
            @(negedge clk);
            n++;
        end
        res = done_data;
        check(done_valid, "R9 completion seen", {31'd0, done_valid}, 32'd1);
        check(done_data == exp, t, done_data, exp);
        check(last_rd_addr == wa, "R2 read address", last_rd_addr, wa);
        check(reads - r0 == 1, "R8/R9 one read", reads - r0, 1);
        if (store) begin
            check(writes - w0 == 1, "R8 one write", writes - w0, 1);
            check(wr_cyc > rsp_cyc, "R8 write after response", wr_cyc, rsp_cyc + 1);
            check(cyc == wr_cyc + 1, "R8 done timing", cyc, wr_cyc + 1);
            check(last_wr_addr == wa, "R8 write address", last_wr_addr, wa);
            check(last_be == 4'hF, "R8 byte enables", {28'd0, last_be}, 32'hF);
            check(mem_m[ea[5:2]] == exp, t, mem_m[ea[5:2]], exp);
        end else begin
            check(writes == w0, intrude ? "R11 no write from ignored command" : "R9 no write",
                  writes - w0, 0);
            check(cyc == rsp_cyc + 1, "R9 done timing", cyc, rsp_cyc + 1);
        end
        @(negedge clk);
        check(!done_valid && !busy, "R9 single-cycle done", {31'd0, done_valid}, 0);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : stim
        logic [31:0] res;
        logic [31:0] r1;
        logic [31:0] exp;
        logic [5:0] ops [4];
        bit seen_busy;
        void'($urandom(32'd4021));
        ops[0] = 6'h22; ops[1] = 6'h26; ops[2] = 6'h2A; ops[3] = 6'h2E;
        for (int i = 0; i < 16; i++) mem_m[i] = 32'h11223344 + 32'h01010101 * i;

        repeat (3) @(negedge clk);
        // R12
        check(!busy && !mem_req_valid && !done_valid, "R12 in reset", {31'd0, busy}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !mem_req_valid && !done_valid, "R12 after reset", {31'd0, busy}, 0);

        // R1: non-matching opcode is ignored
        begin
            int r0 = reads;
            seen_busy = 0;
            cmd_valid = 1'b1; cmd_opcode = 6'h23; cmd_base = 32'h10;
            @(negedge clk);
            cmd_valid = 1'b0;
            repeat (8) begin
                if (busy || done_valid) seen_busy = 1;
                @(negedge clk);
            end
            check(!seen_busy, "R1 illegal opcode idle", {31'd0, seen_busy}, 0);
            check(reads == r0, "R1 illegal opcode no read", reads - r0, 0);
        end

        // Directed: each form, every offset, both byte orders
        for (int e = 0; e < 2; e++)
            for (int o = 0; o < 4; o++)
                for (int k = 0; k < 4; k++)
                    do_op(ops[k], 32'h20 + o, 16'h0, e[0], 32'hA1B2C3D4, 0, res);

        // Negative displacement (R2)
        do_op(6'h22, 32'h104, 16'hFFFD, 1'b1, 32'h0, 0, res);

        // R11: command while busy is dropped
        do_op(6'h26, 32'h31, 16'h0, 1'b1, 32'h55667788, 1, res);
        repeat (6) @(negedge clk);
        check(!busy && !done_valid, "R11 no extra completion", {31'd0, busy}, 0);

        // Misaligned word round trips
        for (int k = 1; k < 4; k++) begin
            logic [31:0] a = 32'h18 + k;
            exp = {mem_byte(a, 1), mem_byte(a + 1, 1), mem_byte(a + 2, 1), mem_byte(a + 3, 1)};
            do_op(6'h22, a, 16'h0, 1'b1, 32'hDEADBEEF, 0, r1);
            do_op(6'h26, a, 16'h3, 1'b1, r1, 0, res);
            check(res == exp, "R3/R4 big-endian round trip", res, exp);
            exp = {mem_byte(a + 3, 0), mem_byte(a + 2, 0), mem_byte(a + 1, 0), mem_byte(a, 0)};
            do_op(6'h26, a, 16'h0, 1'b0, 32'h01234567, 0, r1);
            do_op(6'h22, a, 16'h3, 1'b0, r1, 0, res);
            check(res == exp, "R7 little-endian round trip", res, exp);
        end

        // Constrained random
        for (int i = 0; i < 250; i++) begin
            logic [31:0] b = {26'd0, 6'($urandom)};
            logic [15:0] d = 16'($urandom_range(0, 40)) - 16'd20;
            do_op(ops[$urandom % 4], b + 32'd64, d, 1'($urandom), $urandom, 0, res);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule